// File: doc/BRIEF.md
# Interrupt Pending and Acknowledge Unit

This block sits between interrupt-raising devices and a microcoded processor controller. It turns each device's request into a pending bit, and holds that bit even when the device's request pulse is shorter than the time the processor takes to respond. It keeps the interrupt-enable flag and tells the controller when an interrupt should be taken.

When the controller acknowledges, the block picks the highest-priority pending source. It places that source's index, zero-extended, on the shared data bus. It then clears only that source's pending bit. The controller can also ask the block to place the enable flag itself on the bus. The bus interface is a data word plus an output-enable, which the surrounding bus logic turns into a tri-state driver.

Top module: `irq_ack_unit`

## Requirements
- R1: While `rst_ni` is low, the enable flag is 0, every pending bit is cleared, `take_o` is 0, `bus_oe_o` is 0 and `bus_data_o` is 0.
- R2: At a clock edge with `ie_ld_i` high, the enable flag takes the value of `ie_d_i`. Without `ie_ld_i`, the flag keeps its value. `ie_o` shows the flag.
- R3: `take_o` is 1 exactly when the enable flag is 1 and at least one source is pending.
- R4: A low-to-high transition of `irq_i[k]`, seen at a clock edge, makes source k pending. A request that stays high does not re-arm the pending bit after that bit has been acknowledged.
- R5: A pending bit stays set after its request drops, and stays set while interrupts are disabled, until that source is acknowledged.
- R6: While `ack_i` is high, `bus_oe_o` is 1 and `bus_data_o` holds the 4-bit index of the winning pending source, zero-extended to 32 bits. Source 0 (index 0x1) beats source 1 (index 0x2).
- R7: An acknowledge clears only the winning source's pending bit at the clock edge. Other pending sources stay pending.
- R8: A rising edge on a source's request in the same cycle as that source is acknowledged leaves the source pending.
- R9: With `ie_drv_i` high and `ack_i` low, `bus_oe_o` is 1 and `bus_data_o` is the enable flag in bit 0, with all other bits 0. If both strobes are high, the acknowledge index is driven.
- R10: With `ack_i` and `ie_drv_i` both low, `bus_oe_o` is 0 and `bus_data_o` is 0.
- R11: An acknowledge with nothing pending drives `bus_oe_o` = 1 with data 0 and changes no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 2 | Device request lines; bit 0 has the highest priority |
| ie_ld_i | input | 1 | Load strobe for the enable flag |
| ie_d_i | input | 1 | Value loaded into the enable flag |
| ie_drv_i | input | 1 | Place the enable flag on the bus |
| ack_i | input | 1 | Interrupt acknowledge from the controller |
| take_o | output | 1 | Enabled and a request is pending |
| ie_o | output | 1 | Current enable flag |
| bus_data_o | output | 32 | Data to drive onto the shared bus |
| bus_oe_o | output | 1 | Bus output enable |

## Verification
Two events can fall in the same cycle on one source: the acknowledge that clears its pending bit, and a fresh rising edge of its request. The bench provokes this by letting the request fall one cycle and rise again exactly when the acknowledge is applied. The source must then still be pending, which shows up as `take_o` high and the same index on the next acknowledge. The bench also overlaps the acknowledge with the enable-drive strobe, and a simultaneous rise on both sources, where the index order on the bus decides the result. A behavioural model in the bench predicts every output on every cycle under directed and random stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC_DEF  = 2;
  localparam int unsigned IDX_W_DEF = 4;
  localparam int unsigned BUS_W_DEF = 32;
endpackage

// File: rtl/irq_pend_bit.sv
module irq_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic req_q, pend_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      // a new edge in the clearing cycle wins over the clear
      if (rise)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  a_r5_hold_until_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
  a_r8_rise_survives_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !req_q && clr_i) |=> pend_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NSRC  = irq_pkg::NSRC_DEF,
  parameter int unsigned IDX_W = irq_pkg::IDX_W_DEF,
  parameter logic [NSRC*IDX_W-1:0] SRC_INDEX = '0
) (
  input  logic [NSRC-1:0]  pend_i,
  output logic [NSRC-1:0]  gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest bit number has highest priority: scan downward, last hit wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = SRC_INDEX[i*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int unsigned NSRC  = irq_pkg::NSRC_DEF,
  parameter int unsigned IDX_W = irq_pkg::IDX_W_DEF,
  parameter int unsigned BUS_W = irq_pkg::BUS_W_DEF,
  parameter logic [NSRC*IDX_W-1:0] SRC_INDEX = {4'h2, 4'h1}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  irq_i,
  input  logic             ie_ld_i,
  input  logic             ie_d_i,
  input  logic             ie_drv_i,
  input  logic             ack_i,
  output logic             take_o,
  output logic             ie_o,
  output logic [BUS_W-1:0] bus_data_o,
  output logic             bus_oe_o
);
  localparam int unsigned PAD_W = BUS_W - IDX_W;

  logic             ie_q;
  logic [NSRC-1:0]  pend, gnt;
  logic [IDX_W-1:0] win_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (ie_ld_i) ie_q <= ie_d_i;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    irq_pend_bit i_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (irq_i[k]),
      .clr_i  (ack_i & gnt[k]),
      .pend_o (pend[k])
    );
  end

  irq_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W), .SRC_INDEX(SRC_INDEX)) i_enc (
    .pend_i (pend),
    .gnt_o  (gnt),
    .idx_o  (win_idx)
  );

  assign take_o = ie_q & (|pend);
  assign ie_o   = ie_q;

  always_comb begin
    bus_oe_o   = ack_i | ie_drv_i;
    bus_data_o = '0;
    if (ack_i)         bus_data_o = {{PAD_W{1'b0}}, win_idx};
    else if (ie_drv_i) bus_data_o[0] = ie_q;
  end

  a_r2_ie_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_ld_i |=> (ie_o == $past(ie_d_i)));
  a_r2_ie_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_ld_i |=> $stable(ie_o));
  a_r3_take_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_o |-> !take_o);
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (bus_oe_o && bus_data_o[BUS_W-1:IDX_W] == '0));
  a_r10_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !ie_drv_i) |-> (!bus_oe_o && bus_data_o == '0));
  a_r7_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && ((|pend) == (|gnt)));
endmodule

// File: tb/test_irq_ack_unit.sv
module test_irq_ack_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  irq_i = '0;
  logic        ie_ld_i = 0, ie_d_i = 0, ie_drv_i = 0, ack_i = 0;
  logic        take_o, ie_o, bus_oe_o;
  logic [31:0] bus_data_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit ie_m;
  bit pend_m[2];
  bit prev_m[2];

  always #5 clk_i = ~clk_i;

  irq_ack_unit i_irq_ack_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ie_ld_i(ie_ld_i),
    .ie_d_i(ie_d_i), .ie_drv_i(ie_drv_i), .ack_i(ack_i), .take_o(take_o),
    .ie_o(ie_o), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int winner();
    if (pend_m[0]) return 0;
    if (pend_m[1]) return 1;
    return -1;
  endfunction

  task automatic step(input logic [1:0] irq, input logic ld, input logic d,
                      input logic drv, input logic ack, input string tag);
    int w;
    logic [31:0] exp_data;
    @(negedge clk_i);
    irq_i = irq; ie_ld_i = ld; ie_d_i = d; ie_drv_i = drv; ack_i = ack;
    #1;
    w = winner();
    exp_data = 0;
    if (ack) exp_data = (w < 0) ? 32'd0 : 32'(w + 1);  // index of source k is k+1
    else if (drv) exp_data = {31'd0, ie_m};
    chk({tag, " R3 take"}, {31'd0, take_o}, {31'd0, ie_m && (pend_m[0] || pend_m[1])});
    chk({tag, " R2 ie"}, {31'd0, ie_o}, {31'd0, ie_m});
    chk({tag, " oe"}, {31'd0, bus_oe_o}, {31'd0, ack || drv});
    chk({tag, " data"}, bus_data_o, exp_data);
    @(posedge clk_i);
    for (int k = 0; k < 2; k++) begin
      bit rise;
      rise = irq[k] && !prev_m[k];
      if (ack && w == k) pend_m[k] = rise;
      else if (rise) pend_m[k] = 1'b1;
      prev_m[k] = irq[k];
    end
    if (ld) ie_m = d;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    irq_i = '0; ie_ld_i = 0; ie_d_i = 0; ie_drv_i = 0; ack_i = 0;
    ie_m = 0; pend_m[0] = 0; pend_m[1] = 0; prev_m[0] = 0; prev_m[1] = 0;
    #1;
    chk("R1 reset take", {31'd0, take_o}, 32'd0);
    chk("R1 reset ie", {31'd0, ie_o}, 32'd0);
    chk("R1 reset oe", {31'd0, bus_oe_o}, 32'd0);
    chk("R1 reset data", bus_data_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // pulse on source 0 while disabled: latched but not taken
    step(2'b01, 0, 0, 0, 0, "R10 idle");
    step(2'b00, 0, 0, 0, 0, "R5 disabled");
    step(2'b00, 1, 1, 0, 0, "R5 still held");
    step(2'b00, 0, 0, 1, 0, "R9 drive ie");
    // pulse on source 1, then acknowledge both in priority order
    step(2'b10, 0, 0, 0, 0, "R4 rise src1");
    step(2'b00, 0, 0, 0, 0, "R5 both");
    step(2'b00, 0, 0, 0, 1, "R6 ack src0 first");
    step(2'b00, 0, 0, 1, 1, "R9 ack beats drive R7");
    step(2'b00, 0, 0, 0, 0, "R7 all cleared");
    step(2'b00, 0, 0, 0, 1, "R11 ack empty");
    step(2'b00, 0, 0, 0, 0, "R11 no change");
    // held level does not re-arm after acknowledge
    step(2'b01, 0, 0, 0, 0, "R4 level rise");
    step(2'b01, 0, 0, 0, 1, "R4 ack held");
    step(2'b01, 0, 0, 0, 0, "R4 no rearm");
    step(2'b01, 0, 0, 0, 0, "R4 no rearm 2");
    // new edge in the ack cycle of the same source
    step(2'b00, 0, 0, 0, 0, "R8 drop");
    step(2'b01, 0, 0, 0, 0, "R8 rise");
    step(2'b00, 0, 0, 0, 0, "R8 pend");
    step(2'b01, 0, 0, 0, 1, "R8 rise with ack");
    step(2'b00, 0, 0, 0, 0, "R8 kept pending");
    step(2'b00, 0, 0, 0, 1, "R8 ack again");
    // simultaneous rise on both sources
    step(2'b11, 0, 0, 0, 0, "R6 both rise");
    step(2'b11, 1, 0, 0, 0, "R3 disable");
    step(2'b00, 0, 0, 0, 0, "R3 disabled pending");
    step(2'b00, 0, 0, 0, 1, "R6 src0 index");
    step(2'b00, 0, 0, 1, 1, "R6 src1 index");
    step(2'b00, 1, 1, 0, 0, "R7 empty");
    // reset with pending state
    step(2'b10, 0, 0, 0, 0, "R1 pre");
    do_reset();
    step(2'b00, 0, 0, 0, 0, "R1 after reset");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[1:0], r[2] & r[5], r[3], r[4] & r[5], r[4] & ~r[3], "R6/R7 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule